// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block is the host side of a link to a 12-bit serial-output converter. It drives an active-low chip select and a serial clock, and it shifts in the 16-bit word that the converter returns. A one-cycle command port selects what the next transaction does. It can convert, drop the converter into partial power-down, drop it into full power-down, or wake it. The converter decodes its power mode from how many serial clock falling edges it sees before chip select is released. For that reason each command turns into its own frame shape:

- a full 16-clock frame;
- a frame cut short after a fixed count that lies inside the power-down window;
- a 16-clock dummy frame whose data is thrown away.

The sequencer keeps its own copy of the converter's expected power state. A conversion request made while the converter is down gets a dummy wake frame first, and only the second frame's data is reported. After every frame, chip select stays high for a programmable quiet interval. The serial clock rate is set by a divider parameter given in system-clock cycles.

The result is the low 12 bits of the returned word, with the four leading zeros stripped. It is presented together with a one-cycle valid strobe.

Top module: `adc_frame_seq`

## Requirements
- R1: After reset, `adc_cs_n` is 1, `adc_sclk` is 1, `busy` is 0, `result_valid` is 0 and `pwr_state` is 0. The `pwr_state` encoding is: 0 = on, 1 = partial power-down, 2 = full power-down.
- R2: A convert command (`cmd_op` = 0) while on issues one frame with 16 falling edges of `adc_sclk`. The converter launches word bit 16-k on falling edge k, and the word is sent MSB first. The sequencer samples each bit at the next rising edge. In the cycle that `adc_cs_n` rises, `result_valid` pulses for one cycle, and `result` holds the low 12 bits of the word.
- R3: A partial-down command (`cmd_op` = 1) while on issues one frame with PD_CLOCKS falling edges, where PD_CLOCKS is between 2 and 9. After it, `pwr_state` is 1 and no result is produced.
- R4: A full-down command (`cmd_op` = 2) issues two PD_CLOCKS frames when the state is on, or one such frame when the state is partial. After it, `pwr_state` is 2.
- R5: A wake command (`cmd_op` = 3) while powered down issues one 16-clock dummy frame. It gives no `result_valid`, and afterwards `pwr_state` is 0.
- R6: A convert command while powered down issues a dummy 16-clock frame and then a 16-clock conversion frame. `result_valid` pulses exactly once, and only for the second frame.
- R7: Each frame starts with DIV cycles of chip select low and clock high. Each serial clock is then DIV cycles low followed by DIV cycles high. Between any two frames, `adc_cs_n` stays high for at least QUIET_CYC cycles.
- R8: `busy` rises in the cycle after a command is accepted. It stays high for exactly the sum, over the issued frames, of (2·n+1)·DIV+QUIET_CYC cycles, where n is the clock count of each frame. Commands presented while busy are ignored.
- R9: A command with nothing to do in the current state is not accepted. These are: wake while on, partial-down while not on, and full-down while already fully down. For such a command `busy` stays 0 and no frame is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled while not busy |
| cmd_op | input | 2 | 0 convert, 1 partial-down, 2 full-down, 3 wake |
| busy | output | 1 | High while a command's frames and quiet intervals run |
| pwr_state | output | 2 | Tracked converter power state (0 on, 1 partial, 2 full) |
| adc_cs_n | output | 1 | Chip select to the converter, active low |
| adc_sclk | output | 1 | Serial clock to the converter, idles high |
| adc_sdo | input | 1 | Serial data from the converter |
| result | output | DATA_BITS | Last conversion result |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The assertions assume that `adc_sdo` is driven only while chip select is low. They also assume that commands arrive as single-cycle strobes, with any strobe during a busy period left to the block to drop. The stimulus holds `cmd_valid` for exactly one idle cycle per command, and during busy periods it adds random extra strobes on purpose. The converter model changes `adc_sdo` only on serial clock falling edges. The model decides power transitions itself from the falling-edge count, so the tracked state can be compared against an independent view of the converter.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    OP_CONVERT = 2'd0,
    OP_PARTIAL = 2'd1,
    OP_FULL    = 2'd2,
    OP_WAKE    = 2'd3
  } seq_op_e;

  typedef enum logic [1:0] {
    PW_ON      = 2'd0,
    PW_PARTIAL = 2'd1,
    PW_FULL    = 2'd2
  } pwr_e;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_CONV  = 2'd1,
    FK_DUMMY = 2'd2,
    FK_TRUNC = 2'd3
  } frame_kind_e;

  typedef struct packed {
    logic [1:0]  count;
    frame_kind_e first;
    frame_kind_e second;
  } frame_plan_t;

  // Frames a command expands to, given the tracked power state.
  function automatic frame_plan_t plan_frames(input seq_op_e op, input pwr_e pw);
    frame_plan_t p;
    p.count  = 2'd0;
    p.first  = FK_NONE;
    p.second = FK_NONE;
    case (op)
      OP_CONVERT: begin
        if (pw == PW_ON) begin
          p.count = 2'd1; p.first = FK_CONV;
        end else begin
          p.count = 2'd2; p.first = FK_DUMMY; p.second = FK_CONV;
        end
      end
      OP_PARTIAL: begin
        if (pw == PW_ON) begin
          p.count = 2'd1; p.first = FK_TRUNC;
        end
      end
      OP_FULL: begin
        if (pw == PW_ON) begin
          p.count = 2'd2; p.first = FK_TRUNC; p.second = FK_TRUNC;
        end else if (pw == PW_PARTIAL) begin
          p.count = 2'd1; p.first = FK_TRUNC;
        end
      end
      OP_WAKE: begin
        if (pw != PW_ON) begin
          p.count = 2'd1; p.first = FK_DUMMY;
        end
      end
      default: p.count = 2'd0;
    endcase
    return p;
  endfunction

  // Converter power state once a frame of the given kind completes.
  function automatic pwr_e pwr_after(input pwr_e pw, input frame_kind_e k);
    case (k)
      FK_CONV, FK_DUMMY: return PW_ON;
      FK_TRUNC:          return (pw == PW_ON) ? PW_PARTIAL : PW_FULL;
      default:           return pw;
    endcase
  endfunction

  // Serial clock count for a frame kind.
  function automatic int unsigned frame_clocks(input frame_kind_e k,
                                               input int unsigned full_n,
                                               input int unsigned trunc_n);
    return (k == FK_TRUNC) ? trunc_n : full_n;
  endfunction

endpackage

// File: rtl/seq_sclk_timer.sv
module seq_sclk_timer #(
  parameter int DIV        = 2,
  parameter int MAX_CLOCKS = 16,
  localparam int CW        = $clog2(MAX_CLOCKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] n_clocks,
  output logic          active,
  output logic          sclk,
  output logic          sample_stb,
  output logic          done
);

  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;
  logic [CW:0]   half_q;
  logic [CW-1:0] nclk_q;
  logic          act_q;
  logic          div_wrap;
  logic          last_half;
  logic          sclk_w;

  assign div_wrap  = (div_q == DW'(DIV - 1));
  assign last_half = (half_q == {nclk_q, 1'b0});

  // half 0 is the lead-in (clock high), odd halves low, even halves high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      div_q  <= '0;
      half_q <= '0;
      nclk_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      div_q  <= '0;
      half_q <= '0;
      nclk_q <= n_clocks;
    end else if (act_q) begin
      if (div_wrap) begin
        div_q <= '0;
        if (last_half) act_q <= 1'b0;
        else           half_q <= half_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sclk_w     = !(act_q && half_q[0]);
  assign sclk       = sclk_w;
  assign active     = act_q;
  assign sample_stb = act_q && div_wrap && half_q[0];
  assign done       = act_q && div_wrap && last_half;

  // assertion helper: falling edges seen on the produced clock
  logic          sclk_d_q;
  logic [CW:0]   fall_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q   <= 1'b1;
      fall_cnt_q <= '0;
    end else begin
      sclk_d_q <= sclk_w;
      if (start)                           fall_cnt_q <= '0;
      else if (act_q && sclk_d_q && !sclk_w) fall_cnt_q <= fall_cnt_q + 1'b1;
    end
  end

  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !act_q);

  p_edge_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fall_cnt_q == {1'b0, nclk_q}));

  p_sample_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> $rose(sclk_w));

endmodule

// File: rtl/seq_rx_shift.sv
module seq_rx_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);

  logic [W-1:0] sh_q;

  // leading bits simply fall off the top of a W-bit register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (clear)    sh_q <= '0;
    else if (shift_en) sh_q <= {sh_q[W-2:0], din};
  end

  assign word = sh_q;

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int QUIET_CYC    = 8,
  parameter int FULL_CLOCKS  = 16,
  parameter int TRUNC_CLOCKS = 4,
  parameter int CW           = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          frame_active,
  input  logic          frame_done,
  output logic          start,
  output logic [CW-1:0] n_clocks,
  output logic          conv_end,
  output logic          busy,
  output logic [1:0]    pwr_state
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_QUIET} st_e;

  localparam int QW = (QUIET_CYC > 1) ? $clog2(QUIET_CYC + 1) : 1;
  localparam int HW = QW + 1;

  st_e         st_q;
  pwr_e        pwr_q;
  frame_kind_e kind_q;
  frame_kind_e next_q;
  logic [1:0]  left_q;
  logic [QW-1:0] qcnt_q;

  frame_plan_t plan;
  logic        accept;
  logic        q_last;
  logic        chain;

  assign plan   = plan_frames(seq_op_e'(cmd_op), pwr_q);
  assign accept = (st_q == S_IDLE) && cmd_valid && (plan.count != 2'd0);
  assign q_last = (st_q == S_QUIET) && (qcnt_q == QW'(QUIET_CYC - 1));
  assign chain  = q_last && (left_q != 2'd0);
  assign start  = accept || chain;
  assign n_clocks = CW'(frame_clocks(accept ? plan.first : next_q,
                                     FULL_CLOCKS, TRUNC_CLOCKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pwr_q  <= PW_ON;
      kind_q <= FK_NONE;
      next_q <= FK_NONE;
      left_q <= 2'd0;
      qcnt_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (accept) begin
            st_q   <= S_RUN;
            kind_q <= plan.first;
            next_q <= plan.second;
            left_q <= plan.count - 2'd1;
          end
        end
        S_RUN: begin
          if (frame_done) begin
            pwr_q  <= pwr_after(pwr_q, kind_q);
            st_q   <= S_QUIET;
            qcnt_q <= '0;
          end
        end
        S_QUIET: begin
          if (q_last) begin
            if (chain) begin
              st_q   <= S_RUN;
              kind_q <= next_q;
              left_q <= left_q - 2'd1;
            end else begin
              st_q <= S_IDLE;
            end
          end else begin
            qcnt_q <= qcnt_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign conv_end  = (st_q == S_RUN) && frame_done && (kind_q == FK_CONV);
  assign busy      = (st_q != S_IDLE);
  assign pwr_state = pwr_q;

  // assertion helper: cycles since the serial link went idle
  logic [HW-1:0] idle_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              idle_run_q <= HW'(QUIET_CYC);
    else if (frame_active)                   idle_run_q <= '0;
    else if (idle_run_q < HW'(QUIET_CYC))    idle_run_q <= idle_run_q + 1'b1;
  end

  p_quiet_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (idle_run_q >= HW'(QUIET_CYC - 1)));

  p_busy_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_active |-> busy);

  p_busy_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  p_pwr_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_q) |-> $past(frame_done));

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_seq_pkg::*;
#(
  parameter int DIV        = 2,
  parameter int QUIET_CYC  = 8,
  parameter int PD_CLOCKS  = 4,
  parameter int FRAME_BITS = 16,
  parameter int DATA_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  output logic                 busy,
  output logic [1:0]           pwr_state,
  output logic                 adc_cs_n,
  output logic                 adc_sclk,
  input  logic                 adc_sdo,
  output logic [DATA_BITS-1:0] result,
  output logic                 result_valid
);

  localparam int CW = $clog2(FRAME_BITS + 1);

  logic          start;
  logic [CW-1:0] n_clocks;
  logic          frame_active;
  logic          frame_done;
  logic          sample_stb;
  logic          conv_end;
  logic [DATA_BITS-1:0] rx_word;

  seq_ctrl #(
    .QUIET_CYC   (QUIET_CYC),
    .FULL_CLOCKS (FRAME_BITS),
    .TRUNC_CLOCKS(PD_CLOCKS),
    .CW          (CW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .frame_active(frame_active),
    .frame_done  (frame_done),
    .start       (start),
    .n_clocks    (n_clocks),
    .conv_end    (conv_end),
    .busy        (busy),
    .pwr_state   (pwr_state)
  );

  seq_sclk_timer #(
    .DIV       (DIV),
    .MAX_CLOCKS(FRAME_BITS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .n_clocks  (n_clocks),
    .active    (frame_active),
    .sclk      (adc_sclk),
    .sample_stb(sample_stb),
    .done      (frame_done)
  );

  seq_rx_shift #(
    .W(DATA_BITS)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .shift_en(sample_stb),
    .din     (adc_sdo),
    .word    (rx_word)
  );

  assign adc_cs_n = !frame_active;

  logic [DATA_BITS-1:0] result_q;
  logic                 valid_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= conv_end;
      if (conv_end) result_q <= rx_word;
    end
  end

  assign result       = result_q;
  assign result_valid = valid_q;

  p_valid_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (pwr_state == PW_ON));

  p_valid_csn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $rose(adc_cs_n));

endmodule

// File: tb/tb_adc_frame_seq.sv
module tb_adc_frame_seq;
  localparam int DIV = 2, QUIET = 5, PD = 4, FB = 16, DB = 12;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic busy, cs_n, sclk, result_valid;
  logic [1:0] pwr_state;
  logic sdo = 1'b0;
  logic [DB-1:0] result;

  int checks = 0, errors = 0, exp_pwr = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_frame_seq #(.DIV(DIV), .QUIET_CYC(QUIET), .PD_CLOCKS(PD),
                  .FRAME_BITS(FB), .DATA_BITS(DB)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .pwr_state(pwr_state), .adc_cs_n(cs_n), .adc_sclk(sclk),
    .adc_sdo(sdo), .result(result), .result_valid(result_valid));

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // converter model
  int dev_pwr = 0, dev_falls = 0;
  logic [FB-1:0] dev_word = '0;
  logic [DB-1:0] dev_sample = '0;

  always @(negedge cs_n) begin
    dev_falls = 0;
    if (dev_pwr == 0) begin
      dev_sample = DB'($urandom);
      dev_word   = {{(FB-DB){1'b0}}, dev_sample};
    end else begin
      dev_word = FB'($urandom);
    end
  end

  always @(negedge sclk) if (!cs_n) begin
    dev_falls++;
    if (dev_falls <= FB) sdo = dev_word[FB-dev_falls];
  end

  always @(posedge cs_n) begin
    if (dev_falls >= FB) dev_pwr = 0;
    else if (dev_falls >= 2 && dev_falls < 10) dev_pwr = (dev_pwr == 0) ? 1 : 2;
    dev_falls = 0;
  end

  // link monitor
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  int cur_falls = 0, nfr = 0, nres = 0, gap = 1000;
  int fr_falls [4];

  always @(negedge clk) if (rst_n) begin
    if (!cs_n && prev_sclk && !sclk) cur_falls++;
    if (cs_n && !prev_cs) begin
      if (nfr < 4) fr_falls[nfr] = cur_falls;
      nfr++;
      cur_falls = 0;
      gap = 1;
    end else if (cs_n && gap < 1000) begin
      gap++;
    end
    if (!cs_n && prev_cs) check(gap >= QUIET, "R7 quiet gap before frame", gap, QUIET);
    if (result_valid) begin
      nres++;
      check(result == dev_sample, "R2 result value", int'(result), int'(dev_sample));
    end
    prev_cs   = cs_n;
    prev_sclk = sclk;
  end

  task automatic predict(input int op, input int pw, output int n, output int f0,
                         output int f1, output int nr, output int pa);
    n = 0; f0 = 0; f1 = 0; nr = 0; pa = pw;
    case (op)
      0: begin
        nr = 1; pa = 0;
        if (pw == 0) begin n = 1; f0 = FB; end
        else begin n = 2; f0 = FB; f1 = FB; end
      end
      1: if (pw == 0) begin n = 1; f0 = PD; pa = 1; end
      2: begin
        if (pw == 0) begin n = 2; f0 = PD; f1 = PD; pa = 2; end
        else if (pw == 1) begin n = 1; f0 = PD; pa = 2; end
      end
      default: if (pw != 0) begin n = 1; f0 = FB; pa = 0; end
    endcase
  endtask

  function automatic int frame_busy(input int f);
    return (2 * f + 1) * DIV + QUIET;
  endfunction

  task automatic run_cmd(input int op, input bit poke, input string tag);
    int n, f0, f1, nr, pa, exp_busy, cnt;
    predict(op, exp_pwr, n, f0, f1, nr, pa);
    exp_busy = 0;
    if (n >= 1) exp_busy += frame_busy(f0);
    if (n == 2) exp_busy += frame_busy(f1);
    @(negedge clk);
    nfr = 0; nres = 0;
    cmd_valid = 1'b1; cmd_op = op[1:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    cnt = 0;
    while (busy && cnt < 5000) begin
      cnt++;
      if (poke && cnt == 3) begin
        cmd_valid = 1'b1; cmd_op = 2'($urandom);
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(cnt == exp_busy, {tag, " R8 busy length"}, cnt, exp_busy);
    check(nfr == n, {tag, " frame count"}, nfr, n);
    if (n >= 1) check(fr_falls[0] == f0, {tag, " R3 falls in frame 1"}, fr_falls[0], f0);
    if (n == 2) check(fr_falls[1] == f1, {tag, " R4 falls in frame 2"}, fr_falls[1], f1);
    check(nres == nr, {tag, " R5 result strobes"}, nres, nr);
    check(int'(pwr_state) == pa, {tag, " tracked power"}, int'(pwr_state), pa);
    check(dev_pwr == pa, {tag, " converter power"}, dev_pwr, pa);
    exp_pwr = pa;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n == 1'b1, "R1 cs idle", int'(cs_n), 1);
    check(sclk == 1'b1, "R1 sclk idle", int'(sclk), 1);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(result_valid == 1'b0, "R1 valid", int'(result_valid), 0);
    check(pwr_state == 2'd0, "R1 power on", int'(pwr_state), 0);

    run_cmd(0, 1'b0, "R2 convert while on");
    run_cmd(1, 1'b0, "R3 partial from on");
    run_cmd(0, 1'b0, "R6 convert from partial");
    run_cmd(2, 1'b0, "R4 full from on");
    run_cmd(3, 1'b0, "R5 wake from full");
    run_cmd(3, 1'b0, "R9 wake while on");
    run_cmd(1, 1'b0, "R3 partial again");
    run_cmd(1, 1'b0, "R9 partial while down");
    run_cmd(2, 1'b0, "R4 full from partial");
    run_cmd(2, 1'b0, "R9 full while full");
    run_cmd(0, 1'b0, "R6 convert from full");
    run_cmd(0, 1'b1, "R8 strobe while busy");
    for (int i = 0; i < 40; i++)
      run_cmd(int'($urandom % 4), ($urandom % 3) == 0, "R8 random");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule